// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block sits on the control side of a synchronous DRAM model or controller check. On every rising clock edge it samples the clock-enable, chip-select, the three strobe lines, the auto-precharge address bit, the bank address and the data mask. It turns those inputs into a one-hot command word and a mask of target banks. It also keeps a small state machine for each bank that tracks whether the bank is idle, has an open row, is waiting to auto-precharge or is precharging.

Every command is checked against the bank states. A command that breaks a bank rule raises a one-cycle illegal flag and leaves every bank as it was. Precharge and auto-precharge close a row after a programmable number of clocks. The data mask is turned into two enables with different latencies: a read output-enable that follows the mask two clocks later, and a write enable that acts in the same cycle. All outputs are registered, so a command sampled at edge k appears on the outputs just after edge k.

Top module: `sdcmd_tracker`

## Requirements
- R1: Exactly one bit of `cmd` is set at all times. Its index is the command sampled at the last edge: 0 no-op, 1 deselect, 2 activate, 3 read, 4 write, 5 precharge, 6 auto refresh, 7 self-refresh entry, 8 mode set, 9 burst stop. With chip-select low, {ras_n,cas_n,we_n} decodes as 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode set, 110 burst stop and 111 no-op.
- R2: With `cs_n` high, `cmd` shows deselect, `bank_sel` is zero and the strobe lines have no effect on any bank. Precharge timers keep counting during deselect.
- R3: `bank_sel` bit i stands for bank i. Activate, read and write target the bank given by `ba`. Precharge targets all banks when `a10` is high and bank `ba` otherwise. Mode set and both refresh types target all banks. No-op, burst stop and deselect target none.
- R4: A refresh code decodes as auto refresh when `cke` was high at the previous edge and is high now. It decodes as self-refresh entry when `cke` was high before and is low now. It decodes as no-op when `cke` was low at the previous edge.
- R5: A legal read or write with `a10` high sets `auto_pre`. The addressed bank keeps its row open for BURST_LEN clocks, then precharges for TRP clocks. A read or write to that bank while it waits is illegal.
- R6: Activate is legal only on an idle bank. Read and write are legal only on a bank with an open row that is not waiting to auto-precharge. Mode set and refresh are legal only when every bank is idle. Precharge is always legal.
- R7: An illegal command sets `illegal` for that one cycle and changes no bank state.
- R8: A precharge clears `bank_open` for its target banks just after the edge that samples it. An activate sampled TRP edges after that precharge is accepted; one sampled a clock earlier is illegal.
- R9: `rd_oe` equals the inverse of `dqm` sampled RD_LAT edges earlier (default 2).
- R10: `wr_en` equals the inverse of `dqm` sampled at the same edge (zero latency).
- R11: Under synchronous reset, `cmd` shows no-op, `bank_open`, `bank_sel`, `illegal`, `auto_pre`, `rd_oe` and `wr_en` are all zero, and the previous-CKE state is taken as low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable, sampled each edge |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| a10 | input | 1 | Precharge-all / auto-precharge qualifier |
| ba | input | BAW | Bank address |
| dqm | input | 1 | Data mask, active high |
| cmd | output | NCMD | One-hot decoded command |
| bank_sel | output | NB | Target bank set of the decoded command |
| auto_pre | output | 1 | Legal read/write with auto-precharge |
| illegal | output | 1 | Command violated a bank-state rule |
| bank_open | output | NB | Bank has an open row (including auto-precharge wait) |
| rd_oe | output | 1 | Read output enable after mask latency |
| wr_en | output | 1 | Write data enable, zero latency |

## Verification
On every cycle the assertions check several properties. The command word is one-hot. A legal activate leaves its bank open. A legal mode set or refresh leaves every bank closed. The illegal flag is raised only on commands that have a bank rule. An open bank with no precharge request stays open, and the read mask follows the data mask exactly RD_LAT+1 sampled edges back. Only the bench scenarios can show the exact encodings and target sets, and the refresh split on the previous clock-enable. They also cover the edge on which a precharge timer lets an activate through (also under deselect), the auto-precharge window, and the same-cycle write mask.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  localparam int NCMD = 10;

  typedef enum logic [3:0] {
    C_NOP   = 4'd0,
    C_DESEL = 4'd1,
    C_ACT   = 4'd2,
    C_RD    = 4'd3,
    C_WR    = 4'd4,
    C_PRE   = 4'd5,
    C_AREF  = 4'd6,
    C_SREF  = 4'd7,
    C_MRS   = 4'd8,
    C_BST   = 4'd9
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE  = 2'd0,
    BK_OPEN  = 2'd1,
    BK_AUTOP = 2'd2,
    BK_PRECH = 2'd3
  } bank_st_e;
endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
  import sdcmd_pkg::*;
#(
  parameter int NB  = 4,
  parameter int BAW = $clog2(NB)
) (
  input  logic           cke_prev,
  input  logic           cke,
  input  logic           cs_n,
  input  logic           ras_n,
  input  logic           cas_n,
  input  logic           we_n,
  input  logic           a10,
  input  logic [BAW-1:0] ba,
  output cmd_e           code,
  output logic [NB-1:0]  tgt
);
  logic [NB-1:0] one_bank;
  assign one_bank = NB'(1) << ba;

  always_comb begin
    code = C_NOP;
    tgt  = '0;
    if (cs_n) begin
      code = C_DESEL;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b011: begin code = C_ACT; tgt = one_bank; end
        3'b101: begin code = C_RD;  tgt = one_bank; end
        3'b100: begin code = C_WR;  tgt = one_bank; end
        3'b010: begin code = C_PRE; tgt = a10 ? '1 : one_bank; end
        3'b001: begin
          if (cke_prev) begin
            code = cke ? C_AREF : C_SREF;
            tgt  = '1;
          end
        end
        3'b000: begin code = C_MRS; tgt = '1; end
        3'b110: code = C_BST;
        default: code = C_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdcmd_bank.sv
module sdcmd_bank
  import sdcmd_pkg::*;
#(
  parameter int TRP       = 3,
  parameter int BURST_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic do_act,
  input  logic do_pre,
  input  logic do_ap,
  output logic ready,
  output logic rw_ok,
  output logic open_row
);
  localparam int CMAX = (TRP > BURST_LEN) ? TRP : BURST_LEN;
  localparam int CW   = $clog2(CMAX + 1);

  bank_st_e      st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= BK_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        BK_IDLE: if (do_act) st <= BK_OPEN;
        BK_OPEN: begin
          if (do_pre) begin
            st  <= BK_PRECH;
            cnt <= CW'(TRP - 1);
          end else if (do_ap) begin
            st  <= BK_AUTOP;
            cnt <= CW'(BURST_LEN - 1);
          end
        end
        BK_AUTOP: begin
          if (cnt == '0) begin
            st  <= BK_PRECH;
            cnt <= CW'(TRP - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (cnt == '0) st <= do_act ? BK_OPEN : BK_IDLE;
          else           cnt <= cnt - 1'b1;
        end
      endcase
    end
  end

  assign ready    = (st == BK_IDLE) || (st == BK_PRECH && cnt == '0);
  assign rw_ok    = (st == BK_OPEN);
  assign open_row = (st == BK_OPEN) || (st == BK_AUTOP);

  AST_OPEN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (st == BK_OPEN && !do_pre && !do_ap) |=> (st == BK_OPEN)) else $error("open bank changed"); // R7
  AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (st == BK_OPEN && do_pre) |=> !open_row) else $error("precharge left row open"); // R8
  AST_ACT_READY: assert property (@(posedge clk) disable iff (rst)
    do_act |-> ready) else $error("activate on busy bank"); // R6
endmodule

// File: rtl/sdcmd_dqm.sv
module sdcmd_dqm #(
  parameter int RD_LAT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic dqm,
  output logic rd_oe,
  output logic wr_en
);
  localparam int WMAX = RD_LAT + 2;
  localparam int WW   = $clog2(WMAX + 1);

  logic [RD_LAT-1:0] pipe;

  for (genvar g = 0; g < RD_LAT; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) pipe[0] <= rst ? 1'b1 : dqm;
    end else begin : g_next
      always_ff @(posedge clk) pipe[g] <= rst ? 1'b1 : pipe[g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_oe <= 1'b0;
      wr_en <= 1'b0;
    end else begin
      rd_oe <= ~pipe[RD_LAT-1];
      wr_en <= ~dqm;
    end
  end

  logic [WW-1:0] warm;
  always_ff @(posedge clk) begin
    if (rst)                    warm <= '0;
    else if (warm != WW'(WMAX)) warm <= warm + 1'b1;
  end

  AST_RD_MASK_LAT: assert property (@(posedge clk) disable iff (rst)
    (warm == WW'(WMAX)) |-> (rd_oe == !$past(dqm, RD_LAT + 1))) else $error("read mask latency"); // R9
endmodule

// File: rtl/sdcmd_tracker.sv
module sdcmd_tracker
  import sdcmd_pkg::*;
#(
  parameter int NB        = 4,
  parameter int TRP       = 3,
  parameter int BURST_LEN = 4,
  parameter int RD_LAT    = 2,
  localparam int BAW      = $clog2(NB)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cke,
  input  logic            cs_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic            a10,
  input  logic [BAW-1:0]  ba,
  input  logic            dqm,
  output logic [NCMD-1:0] cmd,
  output logic [NB-1:0]   bank_sel,
  output logic            auto_pre,
  output logic            illegal,
  output logic [NB-1:0]   bank_open,
  output logic            rd_oe,
  output logic            wr_en
);
  logic          cke_prev;
  cmd_e          code;
  logic [NB-1:0] tgt;
  logic [NB-1:0] ready, rw_ok;
  logic [NB-1:0] do_act, do_pre, do_ap;
  logic          ill, is_rw;

  always_ff @(posedge clk) cke_prev <= rst ? 1'b0 : cke;

  sdcmd_decode #(.NB(NB)) u_dec (
    .cke_prev(cke_prev), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .a10(a10), .ba(ba),
    .code(code), .tgt(tgt)
  );

  assign is_rw = (code == C_RD) || (code == C_WR);

  always_comb begin
    case (code)
      C_ACT:                 ill = !ready[ba];
      C_RD, C_WR:            ill = !rw_ok[ba];
      C_MRS, C_AREF, C_SREF: ill = !(&ready);
      default:               ill = 1'b0;
    endcase
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign do_act[b] = (code == C_ACT) && !ill && tgt[b];
    assign do_pre[b] = (code == C_PRE) && tgt[b];
    assign do_ap[b]  = is_rw && a10 && !ill && tgt[b];

    sdcmd_bank #(.TRP(TRP), .BURST_LEN(BURST_LEN)) u_bank (
      .clk(clk), .rst(rst), .do_act(do_act[b]), .do_pre(do_pre[b]),
      .do_ap(do_ap[b]), .ready(ready[b]), .rw_ok(rw_ok[b]),
      .open_row(bank_open[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd      <= NCMD'(1) << C_NOP;
      bank_sel <= '0;
      illegal  <= 1'b0;
      auto_pre <= 1'b0;
    end else begin
      cmd      <= NCMD'(1) << code;
      bank_sel <= tgt;
      illegal  <= ill;
      auto_pre <= |do_ap;
    end
  end

  sdcmd_dqm #(.RD_LAT(RD_LAT)) u_dqm (
    .clk(clk), .rst(rst), .dqm(dqm), .rd_oe(rd_oe), .wr_en(wr_en)
  );

  AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(cmd) == 1) else $error("command not one-hot"); // R1
  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (rst)
    (cmd[C_ACT] && !illegal) |-> ((bank_sel & bank_open) != '0)) else $error("activate did not open"); // R6
  AST_GLOBAL_IDLE: assert property (@(posedge clk) disable iff (rst)
    ((cmd[C_MRS] || cmd[C_AREF] || cmd[C_SREF]) && !illegal) |-> (bank_open == '0)) else $error("global cmd with open bank"); // R6
  AST_ILL_SCOPE: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (cmd[C_ACT] || cmd[C_RD] || cmd[C_WR] || cmd[C_MRS] || cmd[C_AREF] || cmd[C_SREF])) else $error("illegal on unchecked cmd"); // R7
endmodule

// File: tb/sim_sdcmd_tracker.sv
module sim_sdcmd_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int TRP = 3;
  localparam int BL  = 4;
  localparam int NV  = 14;

  logic clk = 1'b0, rst = 1'b1;
  logic cke = 1'b1, cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic a10 = 1'b0, dqm = 1'b1;
  logic [1:0] ba = '0;
  logic [9:0] cmd;
  logic [3:0] bank_sel, bank_open;
  logic auto_pre, illegal, rd_oe, wr_en;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdcmd_tracker #(.TRP(TRP), .BURST_LEN(BL)) u0 (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .a10(a10), .ba(ba), .dqm(dqm), .cmd(cmd), .bank_sel(bank_sel),
    .auto_pre(auto_pre), .illegal(illegal), .bank_open(bank_open),
    .rd_oe(rd_oe), .wr_en(wr_en)
  );

  // {cs,ras,cas,we} a10 ba | expected code | expected sel | expected illegal
  localparam logic [15:0] VEC [NV] = '{
    {4'b0111, 1'b0, 2'd0, 4'd0, 4'b0000, 1'b0},  // R1 nop
    {4'b0011, 1'b0, 2'd0, 4'd2, 4'b0001, 1'b0},  // R6 act b0
    {4'b0011, 1'b0, 2'd0, 4'd2, 4'b0001, 1'b1},  // R7 act open bank
    {4'b0101, 1'b0, 2'd1, 4'd3, 4'b0010, 1'b1},  // R6 read idle bank
    {4'b0101, 1'b0, 2'd0, 4'd3, 4'b0001, 1'b0},  // R1 read
    {4'b0100, 1'b0, 2'd0, 4'd4, 4'b0001, 1'b0},  // R1 write
    {4'b0110, 1'b0, 2'd0, 4'd9, 4'b0000, 1'b0},  // R1 burst stop
    {4'b1011, 1'b0, 2'd3, 4'd1, 4'b0000, 1'b0},  // R2 deselect
    {4'b0000, 1'b0, 2'd0, 4'd8, 4'b1111, 1'b1},  // R6 mode set, bank open
    {4'b0001, 1'b0, 2'd0, 4'd6, 4'b1111, 1'b1},  // R6 refresh, bank open
    {4'b0011, 1'b1, 2'd2, 4'd2, 4'b0100, 1'b0},  // R3 act b2
    {4'b0010, 1'b0, 2'd0, 4'd5, 4'b0001, 1'b0},  // R3 pre one
    {4'b0010, 1'b1, 2'd1, 4'd5, 4'b1111, 1'b0},  // R3 pre all
    {4'b0100, 1'b0, 2'd1, 4'd4, 4'b0010, 1'b1}   // R6 write idle bank
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, return at the next falling edge
  task automatic step(input logic [3:0] c, input logic a, input logic [1:0] b,
                      input logic k, input logic m);
    {cs_n, ras_n, cas_n, we_n} = c;
    a10 = a; ba = b; cke = k; dqm = m;
    @(negedge clk);
  endtask

  task automatic nop(input int n);
    for (int i = 0; i < n; i++) step(4'b0111, 1'b0, 2'd0, 1'b1, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual 0 expected 1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cmd == 10'b1 && bank_open == 0 && bank_sel == 0, "R11 reset cmd/banks", int'(cmd), 1);
    chk(!illegal && !auto_pre && !rd_oe && !wr_en, "R11 reset flags",
        int'({illegal, auto_pre, rd_oe, wr_en}), 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][15:12], VEC[i][11], VEC[i][10:9], 1'b1, 1'b0);
      chk(cmd == (10'd1 << VEC[i][8:5]), "R1 vector cmd", int'(cmd), int'(10'd1 << VEC[i][8:5]));
      chk(bank_sel == VEC[i][4:1], "R3 vector sel", int'(bank_sel), int'(VEC[i][4:1]));
      chk(illegal == VEC[i][0], "R6 vector illegal", int'(illegal), int'(VEC[i][0]));
      if (i == 7) chk(bank_open == 4'b0001, "R2 deselect no activate", int'(bank_open), 1);
      if (i == 8) chk(bank_open == 4'b0001, "R7 state unchanged", int'(bank_open), 1);
    end
    nop(4);
    chk(bank_open == 0, "R8 all closed", int'(bank_open), 0);

    // precharge timing on bank 3
    step(4'b0011, 1'b0, 2'd3, 1'b1, 1'b0);
    chk(bank_open == 4'b1000, "R6 act b3", int'(bank_open), 8);
    step(4'b0010, 1'b0, 2'd3, 1'b1, 1'b0);
    chk(bank_open == 0, "R8 pre closes", int'(bank_open), 0);
    nop(TRP - 2);
    step(4'b0011, 1'b0, 2'd3, 1'b1, 1'b0);
    chk(illegal == 1'b1 && bank_open == 0, "R8 early act illegal", int'(illegal), 1);
    step(4'b0011, 1'b0, 2'd3, 1'b1, 1'b0);
    chk(illegal == 1'b0 && bank_open == 4'b1000, "R8 act after TRP", int'(bank_open), 8);

    // timers run through deselect
    step(4'b0010, 1'b0, 2'd3, 1'b1, 1'b0);
    for (int i = 0; i < TRP - 1; i++) step(4'b1011, 1'b0, 2'd3, 1'b1, 1'b0);
    chk(cmd == 10'b10 && bank_open == 0, "R2 deselect ignored", int'(cmd), 2);
    step(4'b0011, 1'b0, 2'd3, 1'b1, 1'b0);
    chk(illegal == 1'b0 && bank_open == 4'b1000, "R2 timer ran in deselect", int'(bank_open), 8);
    step(4'b0010, 1'b1, 2'd0, 1'b1, 1'b0);
    nop(4);

    // auto-precharge on bank 1
    step(4'b0011, 1'b0, 2'd1, 1'b1, 1'b0);
    step(4'b0101, 1'b1, 2'd1, 1'b1, 1'b0);
    chk(auto_pre == 1'b1 && illegal == 1'b0, "R5 read auto-precharge", int'(auto_pre), 1);
    step(4'b0101, 1'b0, 2'd1, 1'b1, 1'b0);
    chk(illegal == 1'b1 && auto_pre == 1'b0, "R5 read during ap wait", int'(illegal), 1);
    nop(BL - 2);
    chk(bank_open == 4'b0010, "R5 row held for burst", int'(bank_open), 2);
    nop(1);
    chk(bank_open == 0, "R5 row closed", int'(bank_open), 0);
    nop(TRP - 1);
    step(4'b0011, 1'b0, 2'd1, 1'b1, 1'b0);
    chk(illegal == 1'b0 && bank_open == 4'b0010, "R5 reopen after TRP", int'(bank_open), 2);
    step(4'b0010, 1'b1, 2'd0, 1'b1, 1'b0);
    nop(4);

    step(4'b0000, 1'b0, 2'd0, 1'b1, 1'b0);
    chk(cmd == (10'd1 << 8) && illegal == 0 && bank_sel == 4'hf, "R6 mode set idle", int'(cmd), 256);

    // refresh split on clock enable
    step(4'b0001, 1'b0, 2'd0, 1'b1, 1'b0);
    chk(cmd == (10'd1 << 6) && illegal == 0, "R4 auto refresh", int'(cmd), 64);
    step(4'b0001, 1'b0, 2'd0, 1'b0, 1'b0);
    chk(cmd == (10'd1 << 7) && bank_sel == 4'hf, "R4 self refresh entry", int'(cmd), 128);
    step(4'b0001, 1'b0, 2'd0, 1'b0, 1'b0);
    chk(cmd == 10'd1 && bank_sel == 0, "R4 refresh with cke low before", int'(cmd), 1);
    nop(2);

    // data mask latencies
    begin
      logic [6:0] pat;
      pat = 7'b0110010;
      for (int i = 0; i < 7; i++) begin
        step(4'b0111, 1'b0, 2'd0, 1'b1, pat[i]);
        chk(wr_en == !pat[i], "R10 write mask", int'(wr_en), int'(!pat[i]));
        if (i >= 2) chk(rd_oe == !pat[i-2], "R9 read mask", int'(rd_oe), int'(!pat[i-2]));
      end
    end

    finish_run();
  end
endmodule